// File: doc/BRIEF.md
# GPIO Edge Interrupt Vector Controller

This block watches fifteen general-purpose input pins in three ports of five and turns selected edges on them into interrupt vector requests. Every pin first passes through a two-flop synchronizer. An edge detector then compares the synchronized level with the sample taken one cycle earlier. An enabled edge of the chosen polarity latches a sticky pending flag. Software clears a flag by writing a one to its bit.

Ports 0 and 1 have an enable bit and an edge-select bit for each pin. Port 2 has a single enable and a single edge select, and that one setting applies to all five of its pins. The vector map is deliberately uneven. Port 0 has no shared request line. Instead, its pins 1, 3 and 4 each drive a request line of their own, while its pins 0 and 2 only record pending status. Ports 1 and 2 each drive one request line, which is the OR of that port's enabled pending pins.

There is no streaming data path. Software uses a plain synchronous register port: a one-cycle write strobe, and a read strobe whose data appears one cycle later.

Top module: `gpio_irq_vectors`

## Requirements
- R1: After reset, all configuration and pending registers read 0, `irq_vec` is 0 and `bus_rdata` is 0.
- R2: When a pin is enabled and its edge select is 0, a 0-to-1 change on that pin sets its pending bit and the matching vector line. The result is visible after the third rising clock edge following the change, and not after the second.
- R3: When a pin's edge select is 1, a 1-to-0 change sets its pending bit with the same three-edge latency.
- R4: A pin whose enable is 0 never sets its pending bit, whatever edges it sees.
- R5: Port 2 uses one register at address 4. Bit 0 is the group enable and bit 1 is the group edge select. This setting applies equally to all five Port 2 pins.
- R6: The bits of `irq_vec` are assigned as follows. Bit 0 is Port 0 pin 1, bit 1 is Port 0 pin 3, bit 2 is Port 0 pin 4, bit 3 is the OR of the enabled pending bits of Port 1, and bit 4 is the OR of the enabled pending bits of Port 2.
- R7: Port 0 pins 0 and 2 set their pending bits but drive no line of `irq_vec`.
- R8: The pending registers are at address 5 (Port 0), address 6 (Port 1) and address 7 (Port 2). Writing a 1 to a bit of one of these registers clears that bit. Writing a 0 leaves the bit unchanged. No pending bit ever clears without such a write.
- R9: If a qualifying edge and a write-one-to-clear land on the same bit in the same cycle, the bit stays set.
- R10: An edge of the polarity opposite to the selected one does not set the pending bit.
- R11: `bus_rdata` is loaded on the clock edge at which `bus_rd` is high, from the register at `bus_addr`. It holds its value in every cycle in which `bus_rd` is low. The register map is: 0 is the Port 0 enables, 1 is the Port 0 edge selects, 2 is the Port 1 enables, 3 is the Port 1 edge selects, 4 is the Port 2 group setting, and 5 to 7 are the pending registers. Register bit n corresponds to pin n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_pins | input | 5 | Port 0 raw pin levels |
| p1_pins | input | 5 | Port 1 raw pin levels |
| p2_pins | input | 5 | Port 2 raw pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq_vec | output | 5 | Vector request lines |

## Verification
A pin change is due at the outputs after exactly three rising clock edges: two synchronizer stages and the pending register. The bench therefore changes pins on a falling edge and samples `irq_vec` two falling edges later, where the result must still be absent. It samples again one falling edge after that, where the result must be present. Configuration writes and clears take effect at the next rising edge, and read data is due one edge after the strobe, so each bus task drives on one falling edge and samples on the next. The set-beats-clear case is timed so that the clear write is driven on the second falling edge after the pin change, which places the clear on the same rising edge that sets the bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NUM_VEC = 5;

  typedef enum logic [AW-1:0] {
    A_P0_EN   = 3'd0,
    A_P0_EDGE = 3'd1,
    A_P1_EN   = 3'd2,
    A_P1_EDGE = 3'd3,
    A_P2_CFG  = 3'd4,
    A_P0_PEND = 3'd5,
    A_P1_PEND = 3'd6,
    A_P2_PEND = 3'd7
  } reg_addr_e;

  // Port 0 pins with dedicated request lines, in vector order
  localparam int N_DED = 3;
  localparam int DED_PIN [N_DED] = '{1, 3, 4};
  localparam int VEC_P1 = 3;
  localparam int VEC_P2 = 4;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  input  logic [W-1:0] fall_sel,
  output logic [W-1:0] evt
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic s1, s2, prev;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= pin_raw[g];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign evt[g] = fall_sel[g] ? (prev & ~s2) : (s2 & ~prev);
  end
endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | (evt & en);
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int W0 = 5,
  parameter int W1 = 5,
  parameter int W2 = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [W0-1:0] p0_pend,
  input  logic [W1-1:0] p1_pend,
  input  logic [W2-1:0] p2_pend,
  output logic [W0-1:0] p0_en,
  output logic [W0-1:0] p0_fall,
  output logic [W1-1:0] p1_en,
  output logic [W1-1:0] p1_fall,
  output logic          p2_en,
  output logic          p2_fall,
  output logic [W0-1:0] p0_clr,
  output logic [W1-1:0] p1_clr,
  output logic [W2-1:0] p2_clr,
  output logic [DW-1:0] bus_rdata
);
  reg_addr_e   addr;
  logic [DW-1:0] rd_next;
  logic        unused_wbits;

  assign addr         = reg_addr_e'(bus_addr);
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p0_en   <= '0;
      p0_fall <= '0;
      p1_en   <= '0;
      p1_fall <= '0;
      p2_en   <= 1'b0;
      p2_fall <= 1'b0;
    end else if (bus_wr) begin
      case (addr)
        A_P0_EN:   p0_en   <= bus_wdata[W0-1:0];
        A_P0_EDGE: p0_fall <= bus_wdata[W0-1:0];
        A_P1_EN:   p1_en   <= bus_wdata[W1-1:0];
        A_P1_EDGE: p1_fall <= bus_wdata[W1-1:0];
        A_P2_CFG: begin
          p2_en   <= bus_wdata[0];
          p2_fall <= bus_wdata[1];
        end
        default: ;
      endcase
    end
  end

  assign p0_clr = (bus_wr && addr == A_P0_PEND) ? bus_wdata[W0-1:0] : '0;
  assign p1_clr = (bus_wr && addr == A_P1_PEND) ? bus_wdata[W1-1:0] : '0;
  assign p2_clr = (bus_wr && addr == A_P2_PEND) ? bus_wdata[W2-1:0] : '0;

  always_comb begin
    rd_next = '0;
    case (addr)
      A_P0_EN:   rd_next[W0-1:0] = p0_en;
      A_P0_EDGE: rd_next[W0-1:0] = p0_fall;
      A_P1_EN:   rd_next[W1-1:0] = p1_en;
      A_P1_EDGE: rd_next[W1-1:0] = p1_fall;
      A_P2_CFG:  rd_next[1:0]    = {p2_fall, p2_en};
      A_P0_PEND: rd_next[W0-1:0] = p0_pend;
      A_P1_PEND: rd_next[W1-1:0] = p1_pend;
      A_P2_PEND: rd_next[W2-1:0] = p2_pend;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_irq_vectors.sv
module gpio_irq_vectors
  import gpio_irq_pkg::*;
#(
  parameter int P0_PINS = 5,
  parameter int P1_PINS = 5,
  parameter int P2_PINS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P0_PINS-1:0] p0_pins,
  input  logic [P1_PINS-1:0] p1_pins,
  input  logic [P2_PINS-1:0] p2_pins,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [NUM_VEC-1:0] irq_vec
);
  logic [P0_PINS-1:0] p0_en, p0_fall, p0_clr, p0_ev, p0_pend;
  logic [P1_PINS-1:0] p1_en, p1_fall, p1_clr, p1_ev, p1_pend;
  logic [P2_PINS-1:0] p2_clr, p2_ev, p2_pend, p2_en_vec, p2_fall_vec;
  logic               p2_en, p2_fall;

  gpio_irq_regs #(.W0(P0_PINS), .W1(P1_PINS), .W2(P2_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .p0_pend(p0_pend), .p1_pend(p1_pend), .p2_pend(p2_pend),
    .p0_en(p0_en), .p0_fall(p0_fall), .p1_en(p1_en), .p1_fall(p1_fall),
    .p2_en(p2_en), .p2_fall(p2_fall),
    .p0_clr(p0_clr), .p1_clr(p1_clr), .p2_clr(p2_clr),
    .bus_rdata(bus_rdata)
  );

  // Group setting fanned out to every Port 2 pin
  assign p2_en_vec   = {P2_PINS{p2_en}};
  assign p2_fall_vec = {P2_PINS{p2_fall}};

  gpio_sync_edge #(.W(P0_PINS)) u_sync0 (
    .clk(clk), .rst_n(rst_n), .pin_raw(p0_pins), .fall_sel(p0_fall), .evt(p0_ev));
  gpio_sync_edge #(.W(P1_PINS)) u_sync1 (
    .clk(clk), .rst_n(rst_n), .pin_raw(p1_pins), .fall_sel(p1_fall), .evt(p1_ev));
  gpio_sync_edge #(.W(P2_PINS)) u_sync2 (
    .clk(clk), .rst_n(rst_n), .pin_raw(p2_pins), .fall_sel(p2_fall_vec), .evt(p2_ev));

  gpio_pend_bank #(.W(P0_PINS)) u_pend0 (
    .clk(clk), .rst_n(rst_n), .evt(p0_ev), .en(p0_en), .clr(p0_clr), .pend(p0_pend));
  gpio_pend_bank #(.W(P1_PINS)) u_pend1 (
    .clk(clk), .rst_n(rst_n), .evt(p1_ev), .en(p1_en), .clr(p1_clr), .pend(p1_pend));
  gpio_pend_bank #(.W(P2_PINS)) u_pend2 (
    .clk(clk), .rst_n(rst_n), .evt(p2_ev), .en(p2_en_vec), .clr(p2_clr), .pend(p2_pend));

  for (genvar v = 0; v < N_DED; v++) begin : g_ded
    assign irq_vec[v] = p0_pend[DED_PIN[v]] & p0_en[DED_PIN[v]];
  end
  assign irq_vec[VEC_P1] = |(p1_pend & p1_en);
  assign irq_vec[VEC_P2] = |(p2_pend & p2_en_vec);
endmodule

// File: rtl/gpio_irq_vectors_chk.sv
module gpio_irq_vectors_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic [4:0] irq_vec,
  input logic [4:0] p0_en,
  input logic [4:0] p0_ev,
  input logic [4:0] p0_pend,
  input logic [4:0] p1_en,
  input logic [4:0] p1_ev,
  input logic [4:0] p1_pend,
  input logic [4:0] p2_pend
);
  // R9 (also R2): a qualifying edge always leaves its bit set next cycle
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(p1_ev) & $past(p1_en) & ~p1_pend) == 5'd0));
  a_r9_set_wins_p0: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(p0_ev) & $past(p0_en) & ~p0_pend) == 5'd0));
  // R4
  a_r4_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((p0_pend & ~$past(p0_pend) & ~$past(p0_en)) == 5'd0));
  // R8
  a_r8_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((~p1_pend & $past(p1_pend)) == 5'd0));
  // R6
  a_r6_ded_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    !p0_pend[1] |-> !irq_vec[0]);
  a_r6_p2_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (p2_pend == 5'd0) |-> !irq_vec[4]);
  // R11
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_irq_vectors gpio_irq_vectors_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .irq_vec(irq_vec),
  .p0_en(p0_en), .p0_ev(p0_ev), .p0_pend(p0_pend),
  .p1_en(p1_en), .p1_ev(p1_ev), .p1_pend(p1_pend),
  .p2_pend(p2_pend)
);

// File: tb/gpio_irq_vectors_bench.sv
module gpio_irq_vectors_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] p0_pins = '0, p1_pins = '0, p2_pins = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [4:0] irq_vec;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_vectors u_gpio_irq_vectors (
    .clk(clk), .rst_n(rst_n), .p0_pins(p0_pins), .p1_pins(p1_pins), .p2_pins(p2_pins),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_vec(irq_vec)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq_vec", {3'b0, irq_vec}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg %0d", a), d, 8'h00);
    end
  endtask

  task automatic t_rise_p1();
    logic [7:0] d;
    wr(3'd2, 8'h1F);
    @(negedge clk); p1_pins[2] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 not yet after two edges", {3'b0, irq_vec}, 8'h00);
    @(negedge clk);
    chk("R2 vector after three edges", {3'b0, irq_vec}, 8'h08);
    rd(3'd6, d);
    chk("R2 pending readback", d, 8'h04);
    @(negedge clk); p1_pins[2] = 1'b0;
    settle();
    wr(3'd6, 8'h00);
    rd(3'd6, d);
    chk("R8 write zero keeps bit", d, 8'h04);
    wr(3'd6, 8'h04);
    rd(3'd6, d);
    chk("R8 W1C clears and R10 fall ignored", d, 8'h00);
    chk("R8 vector drops", {3'b0, irq_vec}, 8'h00);
  endtask

  task automatic t_fall_p0();
    logic [7:0] d;
    wr(3'd0, 8'h1F);
    wr(3'd1, 8'h1F);
    @(negedge clk); p0_pins = 5'h1F;
    settle();
    rd(3'd5, d);
    chk("R10 rise ignored with falling select", d, 8'h00);
    @(negedge clk); p0_pins[1] = 1'b0;
    settle();
    chk("R3 R6 pin1 vector", {3'b0, irq_vec}, 8'h01);
    @(negedge clk); p0_pins[3] = 1'b0; p0_pins[4] = 1'b0;
    settle();
    chk("R6 pins 3 and 4 vectors", {3'b0, irq_vec}, 8'h07);
    @(negedge clk); p0_pins[0] = 1'b0; p0_pins[2] = 1'b0;
    settle();
    chk("R7 pins 0 and 2 no vector", {3'b0, irq_vec}, 8'h07);
    rd(3'd5, d);
    chk("R7 pins 0 and 2 pending", d, 8'h1F);
    wr(3'd5, 8'h02);
    rd(3'd5, d);
    chk("R8 partial clear", d, 8'h1D);
    chk("R8 R6 vector after partial clear", {3'b0, irq_vec}, 8'h06);
    wr(3'd5, 8'h1F);
    chk("R8 all clear", {3'b0, irq_vec}, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wr(3'd2, 8'h01);
    wr(3'd0, 8'h00);
    @(negedge clk); p1_pins[3] = 1'b1; p0_pins[1] = 1'b1;
    settle();
    @(negedge clk); p0_pins[1] = 1'b0;
    settle();
    rd(3'd6, d);
    chk("R4 disabled P1 pin", d, 8'h00);
    rd(3'd5, d);
    chk("R4 disabled P0 pin", d, 8'h00);
    chk("R4 no vector", {3'b0, irq_vec}, 8'h00);
    @(negedge clk); p1_pins[3] = 1'b0;
    settle();
  endtask

  task automatic t_group_p2();
    logic [7:0] d;
    @(negedge clk); p2_pins = 5'h1F;
    settle();
    @(negedge clk); p2_pins = 5'h00;
    settle();
    rd(3'd7, d);
    chk("R4 R5 group disabled", d, 8'h00);
    wr(3'd4, 8'h03);
    rd(3'd4, d);
    chk("R5 group config readback", d, 8'h03);
    @(negedge clk); p2_pins = 5'h1F;
    settle();
    rd(3'd7, d);
    chk("R5 R10 rise ignored on falling group", d, 8'h00);
    @(negedge clk); p2_pins[0] = 1'b0; p2_pins[4] = 1'b0;
    settle();
    rd(3'd7, d);
    chk("R5 group falling pending", d, 8'h11);
    chk("R6 port 2 vector", {3'b0, irq_vec}, 8'h10);
    wr(3'd7, 8'h1F);
    wr(3'd4, 8'h01);
    @(negedge clk); p2_pins = 5'h00;
    settle();
    @(negedge clk); p2_pins[2] = 1'b1;
    settle();
    rd(3'd7, d);
    chk("R5 group rising pending", d, 8'h04);
    wr(3'd7, 8'h04);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    wr(3'd2, 8'h1F);
    @(negedge clk); p1_pins[0] = 1'b1;
    settle();
    @(negedge clk); p1_pins[0] = 1'b0;
    settle();
    @(negedge clk); p1_pins[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h01;
    @(negedge clk); bus_wr = 1'b0;
    rd(3'd6, d);
    chk("R9 set beats clear", d, 8'h01);
    chk("R9 vector held", {3'b0, irq_vec}, 8'h08);
    wr(3'd6, 8'h01);
  endtask

  task automatic t_read_hold();
    logic [7:0] d;
    rd(3'd6, d);
    chk("R11 read before change", d, 8'h00);
    @(negedge clk); p1_pins[4] = 1'b1;
    settle();
    chk("R11 rdata holds without strobe", bus_rdata, 8'h00);
    rd(3'd6, d);
    chk("R11 read after change", d, 8'h10);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise_p1();
    t_fall_p0();
    t_disabled();
    t_group_p2();
    t_set_wins();
    t_read_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule